// File: doc/BRIEF.md
# Abort Fault Status Capture Unit

This block sits between the memory-management and memory-access logic and the exception entry of a processor core. Each cycle it takes a vector of fault request flags. It drops access-flag requests unless the two mode controls allow them, and picks the highest-priority flag that remains. From that flag it forms a 5-bit fault status code and decides whether the abort goes to the prefetch (instruction) vector or the data vector.

On the next clock edge it updates the status and address registers that the abort type calls for:

- the instruction fault status register;
- the data fault status register, including its 4-bit domain field;
- the fault address register;
- the watchpoint fault address register.

On that same edge it raises a one-cycle abort pulse and a precise flag.

Software reads any of the four registers through a selected read port. The page-table walker, the caches and exception entry are outside this block.

Top module: `abort_status_unit`

## Requirements
- R1: `fault_req` bit i is a fault source, and a lower index means a higher priority. The bits are: 0 alignment, 1 cache maintenance, 2 first-level translation external abort, 3 second-level translation external abort, 4 section translation, 5 page translation, 6 section access flag, 7 page access flag, 8 section domain, 9 page domain, 10 section permission, 11 page permission, 12 precise external abort, 13 imprecise external abort, 14 debug event. Only the highest-priority flag that is allowed is reported.
- R2: Status codes are 5 bits. The top bit goes to register bit 10 and the low four bits go to bits 3:0. The codes are: alignment 00001, cache maintenance 00100, translation external abort 01100 (first level) and 01110 (second level), translation 00101 (section) and 00111 (page), access flag 00011 (section) and 00110 (page), domain 01001 and 01011, permission 01101 and 01111, precise external 01000, imprecise external 10110, debug 00010. All other status bits read as zero.
- R3: The data status domain field (bits 7:4) takes `fault_domain` only for these faults: second-level translation external abort, page translation, either access flag fault, either domain fault, either permission fault, precise external abort and debug. For every other fault the field keeps its old value.
- R4: The fault address register loads `fault_vaddr` for every data abort except an imprecise external abort or a debug event. It changes at no other time.
- R5: Access flag requests (bits 6 and 7) are ignored unless both `af_enable` and `ext_page_mode` are 1.
- R6: When `instr_side` is 1 and the winning fault is not cache maintenance, the block raises `pabt_pulse` and writes only the instruction status register, with its domain bits at zero. The data status and address registers stay unchanged.
- R7: A winning cache maintenance fault is always a data abort, even when `instr_side` is 1. It loads the data status register and the fault address register.
- R8: A data debug abort loads the watchpoint address register with `instr_addr`. Other data aborts, except the precise and imprecise external aborts, load it only when `wfar_on_mmu` is 1.
- R9: `abort_precise` is 0 for a data debug abort and for an imprecise external abort, and 1 for every other abort. An imprecise external abort updates only the data status register.
- R10: Register writes and the single-cycle abort pulse occur on the clock edge that samples the flags. A cycle with no allowed flag raises no pulse and leaves every register unchanged.
- R11: While `rst_n` is low, all registers, pulses and `abort_precise` are zero.
- R12: `rd_data` returns a register chosen by `rd_sel`: 0 instruction status, 1 data status, 2 fault address, 3 watchpoint address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_req | input | 15 | Fault request flags, bit order as in R1 |
| instr_side | input | 1 | 1 = instruction-side access, 0 = data-side access |
| fault_vaddr | input | 32 | Faulting virtual address |
| instr_addr | input | 32 | Address of the faulting instruction |
| fault_domain | input | 4 | Domain number of the access |
| af_enable | input | 1 | Access flag fault enable |
| ext_page_mode | input | 1 | Extended page table mode enable |
| wfar_on_mmu | input | 1 | Watchpoint address capture on non-debug data aborts |
| rd_sel | input | 2 | Register read select |
| rd_data | output | 32 | Selected register value |
| ifsr | output | 32 | Instruction fault status register |
| dfsr | output | 32 | Data fault status register |
| far | output | 32 | Fault address register |
| wfar | output | 32 | Watchpoint fault address register |
| pabt_pulse | output | 1 | One-cycle prefetch abort pulse |
| dabt_pulse | output | 1 | One-cycle data abort pulse |
| abort_precise | output | 1 | Precise flag, valid with an abort pulse |

## Verification
The hardest case to reach from the ports is a stale domain field. It appears only when a fault that writes the domain is followed by a data fault that must not, and the new `fault_domain` value differs from the stored one. The directed part of the bench therefore chains faults with changing domain numbers and checks that bits 7:4 are kept. It also drives a cache maintenance fault while `instr_side` is high, and an access-flag request with only one of the two enables set. A long random phase then sets several flags at once with mixed sides and enables, and a behavioural model checks every cycle.

// File: rtl/abort_pkg.sv
// Shared definitions for the abort fault status capture unit.
// Assumes: a lower source index means a higher priority.
package abort_pkg;

    localparam int NUM_SRC  = 15;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int CODE_W   = 5;
    localparam int DOM_W    = 4;
    localparam int DATA_W   = 32;
    localparam int CODE_HI_BIT = 10;

    typedef enum logic [IDX_W-1:0] {
        F_ALIGN  = 4'd0,
        F_CMAINT = 4'd1,
        F_XL1    = 4'd2,
        F_XL2    = 4'd3,
        F_TRS    = 4'd4,
        F_TRP    = 4'd5,
        F_AFS    = 4'd6,
        F_AFP    = 4'd7,
        F_DMS    = 4'd8,
        F_DMP    = 4'd9,
        F_PMS    = 4'd10,
        F_PMP    = 4'd11,
        F_PEXT   = 4'd12,
        F_IEXT   = 4'd13,
        F_DBG    = 4'd14
    } fault_e;

    // Access-flag sources that are subject to mode gating.
    function automatic logic is_af_src(input int idx);
        return (idx == int'(F_AFS)) || (idx == int'(F_AFP));
    endfunction

    // 5-bit status code of each source.
    function automatic logic [CODE_W-1:0] code_of(input fault_e f);
        case (f)
            F_ALIGN:  return 5'b00001;
            F_CMAINT: return 5'b00100;
            F_XL1:    return 5'b01100;
            F_XL2:    return 5'b01110;
            F_TRS:    return 5'b00101;
            F_TRP:    return 5'b00111;
            F_AFS:    return 5'b00011;
            F_AFP:    return 5'b00110;
            F_DMS:    return 5'b01001;
            F_DMP:    return 5'b01011;
            F_PMS:    return 5'b01101;
            F_PMP:    return 5'b01111;
            F_PEXT:   return 5'b01000;
            F_IEXT:   return 5'b10110;
            F_DBG:    return 5'b00010;
            default:  return 5'b00000;
        endcase
    endfunction

    // Sources whose domain number is meaningful.
    function automatic logic dom_valid(input fault_e f);
        case (f)
            F_ALIGN, F_CMAINT, F_XL1, F_TRS, F_IEXT: return 1'b0;
            default:                                 return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/abort_prio_enc.sv
// Masks mode-gated access-flag requests and picks the lowest-index
// (highest-priority) remaining request.
// Assumes: request flags are valid for a single cycle.
module abort_prio_enc
    import abort_pkg::*;
#(
    parameter int N   = NUM_SRC,
    parameter int IW  = IDX_W
) (
    input  logic [N-1:0]  req,
    input  logic          af_allow,
    output logic          hit,
    output logic [IW-1:0] idx
);

    logic [N-1:0] masked;

    // Per-source gating: access-flag sources need af_allow.
    for (genvar g = 0; g < N; g++) begin : g_mask
        if (is_af_src(g)) begin : g_af
            assign masked[g] = req[g] & af_allow;
        end else begin : g_plain
            assign masked[g] = req[g];
        end
    end

    // Priority search: scan down so the lowest set index wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (masked[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/abort_decode.sv
// Turns the winning source and access side into a status code, a
// vector choice, a precise flag and per-register write enables.
// Assumes: idx is meaningful only when hit is set.
module abort_decode
    import abort_pkg::*;
(
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic              instr_side,
    input  logic              wfar_on_mmu,
    output logic [CODE_W-1:0] code,
    output logic              wr_ifsr,
    output logic              wr_dfsr,
    output logic              wr_dom,
    output logic              wr_far,
    output logic              wr_wfar,
    output logic              precise
);

    fault_e src;
    logic   to_data;
    logic   is_ext;

    assign src = fault_e'(idx);

    // Vector choice: cache maintenance faults always go to the data side.
    always_comb begin
        to_data = !instr_side || (src == F_CMAINT);
        is_ext  = (src == F_PEXT) || (src == F_IEXT);
    end

    // Write-enable and flag derivation per abort type.
    always_comb begin
        code    = code_of(src);
        wr_ifsr = hit && !to_data;
        wr_dfsr = hit && to_data;
        wr_dom  = wr_dfsr && dom_valid(src);
        wr_far  = wr_dfsr && (src != F_IEXT) && (src != F_DBG);
        wr_wfar = wr_dfsr && ((src == F_DBG) || (wfar_on_mmu && !is_ext));
        precise = !(to_data && ((src == F_DBG) || (src == F_IEXT)));
    end

endmodule

// File: rtl/abort_regs.sv
// Holds the four status/address registers, the abort pulses and the
// precise flag, and provides the read-select port.
// Assumes: write enables are mutually consistent (from abort_decode).
module abort_regs
    import abort_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int DMW = DOM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic [DMW-1:0]    domain,
    input  logic [DW-1:0]     vaddr,
    input  logic [DW-1:0]     iaddr,
    input  logic              wr_ifsr,
    input  logic              wr_dfsr,
    input  logic              wr_dom,
    input  logic              wr_far,
    input  logic              wr_wfar,
    input  logic              precise_in,
    input  logic [1:0]        rd_sel,
    output logic [DW-1:0]     ifsr_q,
    output logic [DW-1:0]     dfsr_q,
    output logic [DW-1:0]     far_q,
    output logic [DW-1:0]     wfar_q,
    output logic              pabt_q,
    output logic              dabt_q,
    output logic              precise_q,
    output logic [DW-1:0]     rd_data
);

    localparam int LOW_W  = CODE_W - 1;
    localparam int DOM_LO = LOW_W;

    logic [DW-1:0] ifsr_nx;
    logic [DW-1:0] dfsr_nx;
    logic [DMW-1:0] dom_nx;

    // Next-value formation for both status registers.
    always_comb begin
        dom_nx  = wr_dom ? domain : dfsr_q[DOM_LO +: DMW];
        ifsr_nx = '0;
        ifsr_nx[CODE_HI_BIT]  = code[CODE_W-1];
        ifsr_nx[LOW_W-1:0]    = code[LOW_W-1:0];
        dfsr_nx = ifsr_nx;
        dfsr_nx[DOM_LO +: DMW] = dom_nx;
    end

    // Register update on the edge that samples the fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifsr_q    <= '0;
            dfsr_q    <= '0;
            far_q     <= '0;
            wfar_q    <= '0;
            pabt_q    <= 1'b0;
            dabt_q    <= 1'b0;
            precise_q <= 1'b0;
        end else begin
            pabt_q    <= wr_ifsr;
            dabt_q    <= wr_dfsr;
            precise_q <= (wr_ifsr || wr_dfsr) && precise_in;
            if (wr_ifsr) ifsr_q <= ifsr_nx;
            if (wr_dfsr) dfsr_q <= dfsr_nx;
            if (wr_far)  far_q  <= vaddr;
            if (wr_wfar) wfar_q <= iaddr;
        end
    end

    // Software read select.
    always_comb begin
        case (rd_sel)
            2'd0:    rd_data = ifsr_q;
            2'd1:    rd_data = dfsr_q;
            2'd2:    rd_data = far_q;
            default: rd_data = wfar_q;
        endcase
    end

endmodule

// File: rtl/abort_status_unit.sv
// Top of the abort fault status capture unit: gating and priority,
// abort-type decode, and the register bank.
// Assumes: all inputs are synchronous to clk.
module abort_status_unit
    import abort_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   fault_req,
    input  logic                 instr_side,
    input  logic [DATA_W-1:0]    fault_vaddr,
    input  logic [DATA_W-1:0]    instr_addr,
    input  logic [DOM_W-1:0]     fault_domain,
    input  logic                 af_enable,
    input  logic                 ext_page_mode,
    input  logic                 wfar_on_mmu,
    input  logic [1:0]           rd_sel,
    output logic [DATA_W-1:0]    rd_data,
    output logic [DATA_W-1:0]    ifsr,
    output logic [DATA_W-1:0]    dfsr,
    output logic [DATA_W-1:0]    far,
    output logic [DATA_W-1:0]    wfar,
    output logic                 pabt_pulse,
    output logic                 dabt_pulse,
    output logic                 abort_precise
);

    logic              af_allow;
    logic              hit;
    logic [IDX_W-1:0]  win_idx;
    logic [CODE_W-1:0] code;
    logic              wr_ifsr, wr_dfsr, wr_dom, wr_far, wr_wfar, precise;

    // Access-flag faults need both mode controls.
    assign af_allow = af_enable && ext_page_mode;

    abort_prio_enc #(.N(NUM_SRC), .IW(IDX_W)) u_prio (
        .req      (fault_req),
        .af_allow (af_allow),
        .hit      (hit),
        .idx      (win_idx)
    );

    abort_decode u_dec (
        .hit         (hit),
        .idx         (win_idx),
        .instr_side  (instr_side),
        .wfar_on_mmu (wfar_on_mmu),
        .code        (code),
        .wr_ifsr     (wr_ifsr),
        .wr_dfsr     (wr_dfsr),
        .wr_dom      (wr_dom),
        .wr_far      (wr_far),
        .wr_wfar     (wr_wfar),
        .precise     (precise)
    );

    abort_regs #(.DW(DATA_W), .DMW(DOM_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .code       (code),
        .domain     (fault_domain),
        .vaddr      (fault_vaddr),
        .iaddr      (instr_addr),
        .wr_ifsr    (wr_ifsr),
        .wr_dfsr    (wr_dfsr),
        .wr_dom     (wr_dom),
        .wr_far     (wr_far),
        .wr_wfar    (wr_wfar),
        .precise_in (precise),
        .rd_sel     (rd_sel),
        .ifsr_q     (ifsr),
        .dfsr_q     (dfsr),
        .far_q      (far),
        .wfar_q     (wfar),
        .pabt_q     (pabt_pulse),
        .dabt_q     (dabt_pulse),
        .precise_q  (abort_precise),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/abort_status_chk.sv
// Protocol checker for abort_status_unit, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module abort_status_chk
    import abort_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  fault_req,
    input logic                af_enable,
    input logic                ext_page_mode,
    input logic [DATA_W-1:0]   ifsr,
    input logic [DATA_W-1:0]   dfsr,
    input logic [DATA_W-1:0]   far,
    input logic                pabt_pulse,
    input logic                dabt_pulse,
    input logic                abort_precise
);

    localparam logic [NUM_SRC-1:0] AF_BITS =
        NUM_SRC'((1 << int'(F_AFS)) | (1 << int'(F_AFP)));

    assert_single_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pabt_pulse && dabt_pulse));

    assert_ifsr_needs_pabt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ifsr) |-> pabt_pulse);

    assert_data_regs_hold_on_pabt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pabt_pulse |-> ($stable(dfsr) && $stable(far)));

    assert_far_needs_dabt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(far) |-> dabt_pulse);

    assert_far_hold_imprecise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dabt_pulse && !abort_precise) |-> $stable(far));

    assert_idle_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_req == '0) |=> (!pabt_pulse && !dabt_pulse));

    assert_af_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((fault_req & ~AF_BITS) == '0) && !(af_enable && ext_page_mode))
        |=> (!pabt_pulse && !dabt_pulse));

endmodule

bind abort_status_unit abort_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_req     (fault_req),
    .af_enable     (af_enable),
    .ext_page_mode (ext_page_mode),
    .ifsr          (ifsr),
    .dfsr          (dfsr),
    .far           (far),
    .pabt_pulse    (pabt_pulse),
    .dabt_pulse    (dabt_pulse),
    .abort_precise (abort_precise)
);

// File: tb/abort_status_unit_tb.sv
// Self-checking bench: directed scenarios plus a random phase, with a
// behavioural reference model compared on every clock.
module abort_status_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] fault_req = '0;
    logic        instr_side = 1'b0;
    logic [31:0] fault_vaddr = '0;
    logic [31:0] instr_addr = '0;
    logic [3:0]  fault_domain = '0;
    logic        af_enable = 1'b0;
    logic        ext_page_mode = 1'b0;
    logic        wfar_on_mmu = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data, ifsr, dfsr, far, wfar;
    logic        pabt_pulse, dabt_pulse, abort_precise;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    abort_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .instr_side(instr_side),
        .fault_vaddr(fault_vaddr), .instr_addr(instr_addr), .fault_domain(fault_domain),
        .af_enable(af_enable), .ext_page_mode(ext_page_mode), .wfar_on_mmu(wfar_on_mmu),
        .rd_sel(rd_sel), .rd_data(rd_data), .ifsr(ifsr), .dfsr(dfsr), .far(far),
        .wfar(wfar), .pabt_pulse(pabt_pulse), .dabt_pulse(dabt_pulse),
        .abort_precise(abort_precise)
    );

    // Reference model state.
    logic [31:0] m_ifsr, m_dfsr, m_far, m_wfar;
    logic        m_pabt, m_dabt, m_prec;

    function automatic logic [4:0] ref_code(input int s);
        case (s)
            0: return 5'b00001;  1: return 5'b00100;  2: return 5'b01100;
            3: return 5'b01110;  4: return 5'b00101;  5: return 5'b00111;
            6: return 5'b00011;  7: return 5'b00110;  8: return 5'b01001;
            9: return 5'b01011; 10: return 5'b01101; 11: return 5'b01111;
           12: return 5'b01000; 13: return 5'b10110; default: return 5'b00010;
        endcase
    endfunction

    function automatic bit ref_dom(input int s);
        return !(s == 0 || s == 1 || s == 2 || s == 4 || s == 13);
    endfunction

    // Model update at each clock edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ifsr = 0; m_dfsr = 0; m_far = 0; m_wfar = 0;
            m_pabt = 0; m_dabt = 0; m_prec = 0;
        end else begin
            int w;
            bit data;
            logic [4:0] c;
            w = -1;
            for (int s = 14; s >= 0; s--) begin
                if (fault_req[s] && !((s == 6 || s == 7) && !(af_enable && ext_page_mode)))
                    w = s;
            end
            m_pabt = 0; m_dabt = 0; m_prec = 0;
            if (w >= 0) begin
                c = ref_code(w);
                data = !instr_side || (w == 1);
                m_prec = !(data && (w == 14 || w == 13));
                if (!data) begin
                    m_pabt = 1;
                    m_ifsr = {21'd0, c[4], 6'd0, c[3:0]};
                end else begin
                    m_dabt = 1;
                    m_dfsr = {21'd0, c[4], 2'd0,
                              ref_dom(w) ? fault_domain : m_dfsr[7:4], c[3:0]};
                    if (w != 13 && w != 14) m_far = fault_vaddr;
                    if (w == 14 || (wfar_on_mmu && w != 12 && w != 13)) m_wfar = instr_addr;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            logic [31:0] m_rd;
            case (rd_sel)
                2'd0: m_rd = m_ifsr;
                2'd1: m_rd = m_dfsr;
                2'd2: m_rd = m_far;
                default: m_rd = m_wfar;
            endcase
            check("R6 ifsr model", ifsr, m_ifsr);
            check("R2 dfsr model", dfsr, m_dfsr);
            check("R4 far model", far, m_far);
            check("R8 wfar model", wfar, m_wfar);
            check("R10 pulses model", {30'd0, pabt_pulse, dabt_pulse}, {30'd0, m_pabt, m_dabt});
            check("R9 precise model", {31'd0, abort_precise}, {31'd0, m_prec});
            check("R12 rd_data model", rd_data, m_rd);
        end
    end

    // Apply one cycle of stimulus; returns just after the following falling edge.
    task automatic apply(input logic [14:0] rq, input logic side, input logic [3:0] dm,
                         input logic [31:0] va, input logic [31:0] ia,
                         input logic afe, input logic xp, input logic cfg);
        fault_req = rq; instr_side = side; fault_domain = dm;
        fault_vaddr = va; instr_addr = ia; af_enable = afe;
        ext_page_mode = xp; wfar_on_mmu = cfg;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R11 reset ifsr", ifsr, 0);
        check("R11 reset dfsr", dfsr, 0);
        check("R11 reset far", far, 0);
        check("R11 reset pulses", {30'd0, pabt_pulse, dabt_pulse}, 0);
        rst_n = 1'b1;

        // R1: page translation beats section permission and debug.
        apply(15'h4420, 0, 4'd5, 32'hA000_0001, 32'h1000_0000, 0, 0, 0);
        check("R1 winner code", dfsr, 32'h057);
        check("R4 far loaded", far, 32'hA000_0001);
        // R2 / R9: imprecise external, top code bit, no address capture.
        apply(15'h2000, 0, 4'd9, 32'hBBBB_0000, 32'h1000_0004, 0, 0, 0);
        check("R2 bit10 code", dfsr, 32'h456);
        check("R9 imprecise far kept", far, 32'hA000_0001);
        check("R9 precise low", {31'd0, abort_precise}, 0);
        // R3: first-level external abort keeps the domain field.
        apply(15'h0004, 0, 4'd9, 32'hC000_0000, 32'h1000_0008, 0, 0, 0);
        check("R3 domain kept", dfsr, 32'h05C);
        // R5: access flag with only one enable is ignored.
        apply(15'h0040, 0, 4'd2, 32'hD000_0000, 32'h1000_000C, 1, 0, 0);
        check("R5 af ignored dfsr", dfsr, 32'h05C);
        check("R5 af ignored pulse", {31'd0, dabt_pulse}, 0);
        apply(15'h0040, 0, 4'd2, 32'hD000_0010, 32'h1000_000C, 1, 1, 0);
        check("R5 af enabled", dfsr, 32'h023);
        // R7: cache maintenance on the instruction side is a data abort.
        apply(15'h0002, 1, 4'd7, 32'hE000_0000, 32'h1000_0010, 0, 0, 0);
        check("R7 vector", {30'd0, pabt_pulse, dabt_pulse}, 32'h1);
        check("R7 dfsr", dfsr, 32'h024);
        check("R7 far", far, 32'hE000_0000);
        // R6: instruction-side translation fault.
        apply(15'h0010, 1, 4'd6, 32'hF000_0000, 32'h1000_0014, 0, 0, 0);
        check("R6 pabt", {30'd0, pabt_pulse, dabt_pulse}, 32'h2);
        check("R6 ifsr", ifsr, 32'h005);
        check("R6 dfsr untouched", dfsr, 32'h024);
        check("R6 far untouched", far, 32'hE000_0000);
        // R8: debug loads the watchpoint address regardless of the config bit.
        apply(15'h4000, 0, 4'd3, 32'h1111_0000, 32'h2222_0000, 0, 0, 0);
        check("R8 debug wfar", wfar, 32'h2222_0000);
        check("R9 debug imprecise", {31'd0, abort_precise}, 0);
        check("R4 debug far kept", far, 32'hE000_0000);
        apply(15'h0010, 0, 4'd3, 32'h1111_0004, 32'h3333_0000, 0, 0, 0);
        check("R8 wfar cfg off", wfar, 32'h2222_0000);
        check("R3 section translation domain kept", dfsr, 32'h035);
        apply(15'h0010, 0, 4'd3, 32'h1111_0008, 32'h4444_0000, 0, 0, 1);
        check("R8 wfar cfg on", wfar, 32'h4444_0000);
        // R10: idle cycle.
        apply(15'h0000, 0, 4'd1, 32'h5555_0000, 32'h5555_0000, 1, 1, 1);
        check("R10 no pulse", {30'd0, pabt_pulse, dabt_pulse}, 0);
        check("R10 far kept", far, 32'h1111_0008);
        // R12: read port.
        rd_sel = 2'd0; #1 check("R12 read ifsr", rd_data, 32'h005);
        rd_sel = 2'd1; #1 check("R12 read dfsr", rd_data, 32'h035);
        rd_sel = 2'd2; #1 check("R12 read far", rd_data, 32'h1111_0008);
        rd_sel = 2'd3; #1 check("R12 read wfar", rd_data, 32'h4444_0000);

        // Random phase; the model comparison covers all requirements.
        for (int n = 0; n < 1500; n++) begin
            logic [14:0] rq;
            rq = '0;
            for (int k = 0; k < 3; k++)
                if ($urandom_range(0, 3) != 0) rq[$urandom_range(0, 14)] = 1'b1;
            rd_sel = 2'($urandom_range(0, 3));
            apply(rq, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                  $urandom, $urandom, 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        fault_req = '0;
        @(negedge clk); #1;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule